// File: doc/BRIEF.md
# Moving-Average DC Offset Remover

This block takes a stream of signed two's-complement samples and takes the DC offset out of it. Each accepted sample first joins a window made of that sample and the AVG_LEN-1 accepted samples before it. The block averages that window with equal weights and subtracts the average from the same sample. The output is therefore the sample with its local mean removed, not the smoothed mean. When COMPLEX is set, an in-phase/quadrature pair travels on the same valid strobe, and each rail keeps its own independent history and sum.

The average comes from a running sum: the newest sample is added, the sample that drops out of the window is subtracted, and the sum is kept at full precision. The division by the window length happens once, on the final sum, with round-to-nearest. The difference is then clamped to the sample width. The history starts at zero, so the estimate ramps up over the first AVG_LEN samples. Each result appears two clock cycles after the sample that produced it. Cycles without a valid input leave the state untouched.

Top module: `dc_offset_remover`

## Requirements
- R1: For every accepted sample x, the output is x - round(S/AVG_LEN), where S is the exact sum of x and the AVG_LEN-1 previously accepted samples on the same rail. Samples and results are two's-complement signed, DATA_W bits wide.
- R2: After reset, every history slot that has not yet been written counts as zero. The estimate therefore ramps from zero over the first AVG_LEN samples.
- R3: The running sum is held without wrap-around. Its magnitude never exceeds AVG_LEN * 2^(DATA_W-1).
- R4: The division rounds to the nearest integer. An exact half rounds away from zero, so a sum of +25 with AVG_LEN=50 gives an estimate of +1, and -25 gives -1.
- R5: If the difference leaves the signed DATA_W range, the output clamps to the largest positive or most negative code.
- R6: out_valid equals in_valid delayed by exactly two clock cycles. A cycle with in_valid low neither advances the history nor changes the sum.
- R7: While out_valid is low, out_re and out_im keep the value of the last valid result (zero after reset).
- R8: With COMPLEX=1, the in_re and in_im rails are processed independently, each with its own history and sum.
- R9: A synchronous active-high reset clears the history, the sums, out_valid and both output samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_re and in_im |
| in_re | input | DATA_W | Real (or only) input sample, signed |
| in_im | input | DATA_W | Imaginary input sample, signed; unused when COMPLEX=0 |
| out_valid | output | 1 | Qualifies out_re and out_im |
| out_re | output | DATA_W | Real output sample, offset removed |
| out_im | output | DATA_W | Imaginary output sample; zero when COMPLEX=0 |

## Verification
In a single cycle the oldest sample leaves the window while the newest enters it, and the rounded division and the output saturation can both act on that one result. The bench provokes this by holding the input at full negative scale for a whole window and then stepping to full positive scale. At that step the departing sample, the rounding of a large negative sum and the clamp all meet. A second pattern drives a lone sample of ±25 right after reset to land exactly on a rounding tie. Every cycle is compared against a behavioural model that keeps a plain integer window per rail and rounds by quotient and remainder.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  // Width of the scratch arithmetic used for estimate and difference.
  localparam int WIDE_W = 48;
  typedef logic signed [WIDE_W-1:0] wide_t;

  // Divide by a positive constant, round to nearest, halves away from zero.
  function automatic wide_t div_round(input wide_t num, input int unsigned den);
    wide_t mag;
    wide_t quo;
    mag = (num < 0) ? -num : num;
    quo = (mag + wide_t'(den / 2)) / wide_t'(den);
    return (num < 0) ? -quo : quo;
  endfunction

  // Clamp a wide value into the signed range of the given width.
  function automatic wide_t sat_to(input wide_t val, input int unsigned w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (w - 1));
    if (val > hi) return hi;
    if (val < lo) return lo;
    return val;
  endfunction

endpackage

// File: rtl/dcr_history.sv
// Circular window of the last DEPTH accepted samples. The slot under the
// write pointer always holds the sample that is about to leave the window.
module dcr_history #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 50
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic signed [DATA_W-1:0] newest,
  output logic signed [DATA_W-1:0] leaving
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic signed [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]         wr_ptr_q;
  logic [PTR_W-1:0]         wr_ptr_nxt;

  assign wr_ptr_nxt = (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + PTR_W'(1);
  assign leaving    = slot_q[wr_ptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (push) begin
      slot_q[wr_ptr_q] <= newest;
      wr_ptr_q         <= wr_ptr_nxt;
    end
  end

endmodule

// File: rtl/dcr_accumulator.sv
// First pipeline stage: running window sum at full precision plus a copy of
// the sample that the sum now includes.
module dcr_accumulator #(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic signed [DATA_W-1:0] newest,
  input  logic signed [DATA_W-1:0] leaving,
  output logic                     stg_valid,
  output logic signed [DATA_W-1:0] stg_sample,
  output logic signed [SUM_W-1:0]  stg_sum
);

  localparam int EXT_W = SUM_W - DATA_W;

  logic signed [SUM_W-1:0] add_term;
  logic signed [SUM_W-1:0] sub_term;
  logic signed [SUM_W-1:0] sum_nxt;

  assign add_term = {{EXT_W{newest[DATA_W-1]}}, newest};
  assign sub_term = {{EXT_W{leaving[DATA_W-1]}}, leaving};
  assign sum_nxt  = stg_sum + add_term - sub_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_valid  <= 1'b0;
      stg_sample <= '0;
      stg_sum    <= '0;
    end else begin
      stg_valid <= push;
      if (push) begin
        stg_sample <= newest;
        stg_sum    <= sum_nxt;
      end
    end
  end

endmodule

// File: rtl/dcr_output_stage.sv
// Second pipeline stage: one rounded division of the window sum, subtraction
// from the matching sample, clamp, register.
module dcr_output_stage
  import dcr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 50,
  parameter int SUM_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stg_valid,
  input  logic signed [DATA_W-1:0] stg_sample,
  input  logic signed [SUM_W-1:0]  stg_sum,
  output logic                     res_valid,
  output logic signed [DATA_W-1:0] res_sample
);

  localparam int SUM_EXT  = WIDE_W - SUM_W;
  localparam int DATA_EXT = WIDE_W - DATA_W;

  wide_t sum_wide;
  wide_t sample_wide;
  wide_t estimate;
  wide_t diff;
  wide_t clamped;

  assign sum_wide    = {{SUM_EXT{stg_sum[SUM_W-1]}}, stg_sum};
  assign sample_wide = {{DATA_EXT{stg_sample[DATA_W-1]}}, stg_sample};
  assign estimate    = div_round(sum_wide, DEPTH);
  assign diff        = sample_wide - estimate;
  assign clamped     = sat_to(diff, DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_sample <= '0;
    end else begin
      res_valid <= stg_valid;
      if (stg_valid) res_sample <= clamped[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/dcr_rail.sv
// One independent rail: window storage, running sum, estimate and subtract.
module dcr_rail #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 50,
  parameter int SUM_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample,
  output logic signed [SUM_W-1:0]  run_sum
);

  logic signed [DATA_W-1:0] leaving;
  logic                     stg_valid;
  logic signed [DATA_W-1:0] stg_sample;

  dcr_history #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_history (
    .clk     (clk),
    .rst     (rst),
    .push    (in_valid),
    .newest  (in_sample),
    .leaving (leaving)
  );

  dcr_accumulator #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_accum (
    .clk        (clk),
    .rst        (rst),
    .push       (in_valid),
    .newest     (in_sample),
    .leaving    (leaving),
    .stg_valid  (stg_valid),
    .stg_sample (stg_sample),
    .stg_sum    (run_sum)
  );

  dcr_output_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SUM_W(SUM_W)) i_out (
    .clk        (clk),
    .rst        (rst),
    .stg_valid  (stg_valid),
    .stg_sample (stg_sample),
    .stg_sum    (run_sum),
    .res_valid  (out_valid),
    .res_sample (out_sample)
  );

endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover #(
  parameter int DATA_W  = 16,
  parameter int AVG_LEN = 50,
  parameter bit COMPLEX = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);

  localparam int NUM_RAILS = COMPLEX ? 2 : 1;
  localparam int LEN_BITS  = (AVG_LEN > 1) ? $clog2(AVG_LEN) : 0;
  localparam int SUM_W     = DATA_W + LEN_BITS + 1;

  logic signed [DATA_W-1:0] rail_in  [NUM_RAILS];
  logic signed [DATA_W-1:0] rail_out [NUM_RAILS];
  logic signed [SUM_W-1:0]  rail_sum [NUM_RAILS];
  logic [NUM_RAILS-1:0]     rail_vld;

  // Named monitor wires for the bound checker.
  logic signed [SUM_W-1:0]  mon_sum_re;
  logic signed [SUM_W-1:0]  mon_sum_im;

  assign rail_in[0] = in_re;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    dcr_rail #(.DATA_W(DATA_W), .DEPTH(AVG_LEN), .SUM_W(SUM_W)) i_rail (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (rail_in[g]),
      .out_valid  (rail_vld[g]),
      .out_sample (rail_out[g]),
      .run_sum    (rail_sum[g])
    );
  end

  if (COMPLEX) begin : g_cplx
    assign rail_in[NUM_RAILS-1] = in_im;
    assign out_im               = rail_out[NUM_RAILS-1];
    assign mon_sum_im           = rail_sum[NUM_RAILS-1];
  end else begin : g_real
    assign out_im     = '0;
    assign mon_sum_im = '0;
  end

  assign out_valid  = &rail_vld;
  assign out_re     = rail_out[0];
  assign mon_sum_re = rail_sum[0];

endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int DATA_W  = 16,
  parameter int AVG_LEN = 50,
  parameter int SUM_W   = 23
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_re,
  input logic signed [DATA_W-1:0] out_im,
  input logic signed [SUM_W-1:0]  sum_re,
  input logic signed [SUM_W-1:0]  sum_im
);

  localparam int SUM_EXT = 48 - SUM_W;
  localparam logic signed [47:0] BOUND =
    48'(AVG_LEN) * (48'sd1 <<< (DATA_W - 1));

  logic [1:0]         since_rst;
  logic signed [47:0] wide_re;
  logic signed [47:0] wide_im;

  assign wide_re = {{SUM_EXT{sum_re[SUM_W-1]}}, sum_re};
  assign wide_im = {{SUM_EXT{sum_im[SUM_W-1]}}, sum_im};

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R6: fixed two-cycle valid latency
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R6: an idle input cycle leaves both sums untouched
  a_r6_idle_sum_stable: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_re) && $stable(sum_im)));

  // R7: outputs hold while not valid
  a_r7_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 2'd2) && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

  // R3: running sums stay inside the exact window bound
  a_r3_sum_bound: assert property (@(posedge clk) disable iff (rst)
    (wide_re <= BOUND) && (wide_re >= -BOUND) &&
    (wide_im <= BOUND) && (wide_im >= -BOUND));

endmodule

bind dc_offset_remover dcr_checker #(
  .DATA_W  (DATA_W),
  .AVG_LEN (AVG_LEN),
  .SUM_W   (SUM_W)
) i_dcr_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im),
  .sum_re    (mon_sum_re),
  .sum_im    (mon_sum_im)
);

// File: tb/test_dc_offset_remover.sv
`timescale 1ns/1ps
module test_dc_offset_remover;

  localparam int DATA_W  = 16;
  localparam int AVG_LEN = 50;
  localparam int MAXV    = 32767;
  localparam int MINV    = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_re = '0;
  logic signed [DATA_W-1:0] in_im = '0;
  logic out_valid;
  logic signed [DATA_W-1:0] out_re;
  logic signed [DATA_W-1:0] out_im;

  always #2 clk = ~clk;

  dc_offset_remover #(.DATA_W(DATA_W), .AVG_LEN(AVG_LEN), .COMPLEX(1'b1)) i_dc_offset_remover (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R9";

  // Behavioural model: integer window per rail, newest first.
  int hist [2][AVG_LEN];
  int last_re = 0, last_im = 0;
  bit d1v = 0, d2v = 0;
  int d1re = 0, d1im = 0, d2re = 0, d2im = 0;

  function automatic int model_step(int rail, int x);
    longint s;
    longint q;
    longint r;
    longint y;
    for (int k = AVG_LEN - 1; k > 0; k--) hist[rail][k] = hist[rail][k-1];
    hist[rail][0] = x;
    s = 0;
    for (int k = 0; k < AVG_LEN; k++) s += hist[rail][k];
    q = s / AVG_LEN;
    r = s % AVG_LEN;
    if (r < 0) r = -r;
    if (2 * r >= AVG_LEN) q += (s < 0) ? -1 : 1;
    y = x - q;
    if (y > MAXV) y = MAXV;
    if (y < MINV) y = MINV;
    return int'(y);
  endfunction

  task automatic model_clear();
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < AVG_LEN; k++) hist[r][k] = 0;
    last_re = 0; last_im = 0;
    d1v = 0; d2v = 0; d1re = 0; d1im = 0; d2re = 0; d2im = 0;
  endtask

  task automatic check_outputs();
    checks++;
    if (out_valid !== d2v || int'(out_re) != d2re || int'(out_im) != d2im) begin
      errors++;
      $display("FAIL %s: actual v=%0b re=%0d im=%0d expected v=%0b re=%0d im=%0d",
               cur_req, out_valid, out_re, out_im, d2v, d2re, d2im);
    end
  endtask

  task automatic step(bit v, int re, int im);
    @(negedge clk);
    check_outputs();
    d2v = d1v; d2re = d1re; d2im = d1im;
    if (v) begin
      last_re = model_step(0, re);
      last_im = model_step(1, im);
    end
    d1v = v; d1re = last_re; d1im = last_im;
    rst = 1'b0;
    in_valid = v;
    in_re = DATA_W'(re);
    in_im = DATA_W'(im);
  endtask

  task automatic do_reset(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0;
      model_clear();
    end
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  initial begin
    void'($urandom(7));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);   // first clear edge has passed; model is in reset state

    cur_req = "R9";   // reset state: idle outputs are zero and not valid
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    cur_req = "R4";   // exact half with empty history: +25 -> est +1, -25 -> est -1
    step(1, 25, -25);
    step(0, 0, 0);
    step(1, -25, 25);
    for (int i = 0; i < 3; i++) step(0, 0, 0);

    cur_req = "R2";   // ramp of the estimate from an all-zero history
    do_reset(2);
    for (int i = 0; i < 60; i++) step(1, 1000, -700);
    cur_req = "R1";
    for (int i = 0; i < 60; i++) step(1, 1000 + ((i % 2) ? 300 : -300), -700 + i);

    cur_req = "R8";   // constant real rail, random imaginary rail
    for (int i = 0; i < 80; i++) step(1, 500, rnd_sample());

    cur_req = "R6 R7"; // irregular valid strobes, hold between results
    for (int i = 0; i < 200; i++)
      step(($urandom_range(1) == 1), rnd_sample() / 4 + 2000, rnd_sample() / 8 - 1500);

    cur_req = "R5";   // full negative window then full positive step, and reverse
    for (int i = 0; i < AVG_LEN; i++) step(1, MINV, MAXV);
    step(1, MAXV, MINV);
    step(1, MAXV, MINV);
    for (int i = 0; i < AVG_LEN; i++) step(1, MAXV, MINV);
    step(1, MINV, MAXV);
    step(0, 0, 0);

    cur_req = "R3";   // full-scale random data exercises the exact sum
    for (int i = 0; i < 200; i++) step(1, rnd_sample(), rnd_sample());

    cur_req = "R9";   // reset in mid stream, then restart from zero history
    step(1, 12000, -9000);
    do_reset(1);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 12000, -9000);
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6: watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule